// File: doc/BRIEF.md
# Pipeline Exception and Flush Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) when the execute stage reports a fault. In the cycle the fault is seen, it raises flush for the faulting instruction and for the two younger instructions behind it, so none of them writes memory or a register. It leaves the two older instructions in memory access and write-back untouched, so they retire. In that same cycle it selects a fixed trap vector as the next fetch address. At the following clock edge it saves the faulting PC and a 4-bit cause code into two holding registers.

The same flush and redirect outputs also carry an ordinary taken branch that is resolved in decode. That branch squashes only the fetch stage and steers fetch to the branch target. When a branch and a fault arrive together, the fault wins. The pipeline's stage registers use `flush` to clear their control fields. The fetch unit loads `pc_next` whenever `pc_sel` is not sequential.

Top module: `exc_flush_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `saved_pc` and `saved_cause` to zero.
- R2: When `exc_req` is high and `stage_valid[2]` (execute) is high, `flush[2:0]` (execute, decode, fetch) is all ones in that same cycle.
- R3: `flush[3]` (memory) and `flush[4]` (write-back) are never asserted, whatever the inputs.
- R4: In the cycle a fault is taken, `pc_sel` is 2 (trap) and `pc_next` equals the trap vector 0x0000_0000_1C09_0000.
- R5: At the clock edge that ends a cycle in which a fault is taken, `saved_pc` takes `ex_pc` and `saved_cause` takes `exc_cause`.
- R6: `saved_pc` and `saved_cause` keep their values through every cycle in which no fault is taken.
- R7: An `exc_req` while `stage_valid[2]` is low is ignored: it causes no flush and no redirect, and the saved registers do not change.
- R8: A taken branch (`br_taken`) with no fault sets `flush` to 5'b00001 (fetch only), `pc_sel` to 1 (branch) and `pc_next` to `br_target`.
- R9: When a taken fault and `br_taken` occur in the same cycle, the fault redirect wins: flush covers stages 0 to 2, `pc_sel` is 2 and `pc_next` is the trap vector.
- R10: With no fault taken and no branch, `flush` is zero, `pc_sel` is 0 (sequential) and `pc_next` is zero.
- R11: Every 4-bit cause value is recorded unchanged. The named codes are 0x2 for an undefined opcode, 0x8 for a system call and 0xA for an arithmetic fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_valid | input | 5 | Valid bit per stage; bit 0 is fetch, bit 4 is write-back |
| ex_pc | input | 64 | PC of the instruction in execute |
| exc_req | input | 1 | Fault reported by execute |
| exc_cause | input | 4 | Cause code that comes with `exc_req` |
| br_taken | input | 1 | Taken branch resolved in decode |
| br_target | input | 64 | Target of the taken branch |
| flush | output | 5 | Per-stage squash; bit 0 is fetch |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 trap |
| pc_next | output | 64 | Override fetch address; zero when sequential |
| saved_pc | output | 64 | PC of the most recent taken fault |
| saved_cause | output | 4 | Cause of the most recent taken fault |

## Verification
The vector table drives an idle pipeline, a lone fault, a lone branch, and a fault request with execute empty. It also drives a fault and a branch together, and an empty execute stage paired with a branch. Side by side, these cases separate the fault path from the branch path, show whether the execute valid bit gates the fault, and show which redirect wins. The cause values include all three named codes plus 0xF, and one PC sets every upper bit, so a narrowed or reordered save path shows up. Directed steps then check the reset value, the hold over idle cycles, and a reset that arrives after the registers have been loaded.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    // Stage positions inside the per-stage vectors (age order matters).
    localparam int STG_FETCH  = 0;
    localparam int STG_DECODE = 1;
    localparam int STG_EXEC   = 2;
    localparam int STG_MEMACC = 3;
    localparam int STG_RETIRE = 4;
    localparam int STG_COUNT  = 5;

    localparam int CAUSE_BITS = 4;

    typedef enum logic [1:0] {
        PCSRC_SEQ    = 2'd0,
        PCSRC_BRANCH = 2'd1,
        PCSRC_TRAP   = 2'd2
    } pc_src_e;

    localparam logic [CAUSE_BITS-1:0] CAUSE_BAD_OPCODE = 4'h2;
    localparam logic [CAUSE_BITS-1:0] CAUSE_SYSCALL    = 4'h8;
    localparam logic [CAUSE_BITS-1:0] CAUSE_ARITH      = 4'hA;

    // Kind of redirect requested this cycle.
    typedef struct packed {
        logic fault;
        logic branch;
    } redirect_t;

    function automatic pc_src_e pick_src(redirect_t r);
        if (r.fault)
            return PCSRC_TRAP;
        else if (r.branch)
            return PCSRC_BRANCH;
        else
            return PCSRC_SEQ;
    endfunction

endpackage

// File: rtl/exc_qualify.sv
module exc_qualify
    import exc_ctrl_pkg::*;
(
    input  logic      exc_req,
    input  logic      ex_valid,
    input  logic      br_taken,
    output redirect_t rd
);
    always_comb begin
        rd.fault  = exc_req & ex_valid;
        rd.branch = br_taken;
    end
endmodule

// File: rtl/exc_flush_gen.sv
module exc_flush_gen #(
    parameter int NSTAGE = 5,
    parameter int EX_IDX = 2,
    parameter int BR_IDX = 1
) (
    input  logic              fault,
    input  logic              branch,
    output logic [NSTAGE-1:0] flush
);
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s <= EX_IDX && s < BR_IDX) begin : g_both
            assign flush[s] = fault | branch;
        end else if (s <= EX_IDX) begin : g_fault
            assign flush[s] = fault;
        end else begin : g_keep
            assign flush[s] = 1'b0;
        end
    end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
    import exc_ctrl_pkg::*;
#(
    parameter int              XLEN    = 64,
    parameter logic [XLEN-1:0] TRAP_PC = 64'h0000_0000_1C09_0000
) (
    input  redirect_t       rd,
    input  logic [XLEN-1:0] br_target,
    output pc_src_e         src,
    output logic [XLEN-1:0] pc_next
);
    always_comb begin
        src = pick_src(rd);
        unique case (src)
            PCSRC_TRAP:   pc_next = TRAP_PC;
            PCSRC_BRANCH: pc_next = br_target;
            default:      pc_next = '0;
        endcase
    end
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fault,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [CAUSE_W-1:0] cause_in,
    output logic [XLEN-1:0]    pc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            cause_q <= '0;
        end else if (fault) begin
            pc_q    <= pc_in;
            cause_q <= cause_in;
        end
    end

    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        fault |=> (pc_q == $past(pc_in)) && (cause_q == $past(cause_in))); // R5
    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fault |=> $stable(pc_q) && $stable(cause_q)); // R6
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter int              XLEN    = 64,
    parameter int              CAUSE_W = CAUSE_BITS,
    parameter int              NSTAGE  = STG_COUNT,
    parameter logic [XLEN-1:0] TRAP_PC = 64'h0000_0000_1C09_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTAGE-1:0]  stage_valid,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               br_taken,
    input  logic [XLEN-1:0]    br_target,
    output logic [NSTAGE-1:0]  flush,
    output logic [1:0]         pc_sel,
    output logic [XLEN-1:0]    pc_next,
    output logic [XLEN-1:0]    saved_pc,
    output logic [CAUSE_W-1:0] saved_cause
);
    localparam int EX_IDX = STG_EXEC;
    localparam int BR_IDX = STG_DECODE;

    redirect_t rd;
    pc_src_e   src;

    exc_qualify u_qual (
        .exc_req  (exc_req),
        .ex_valid (stage_valid[EX_IDX]),
        .br_taken (br_taken),
        .rd       (rd)
    );

    exc_flush_gen #(.NSTAGE(NSTAGE), .EX_IDX(EX_IDX), .BR_IDX(BR_IDX)) u_flush (
        .fault  (rd.fault),
        .branch (rd.branch),
        .flush  (flush)
    );

    exc_redirect #(.XLEN(XLEN), .TRAP_PC(TRAP_PC)) u_redir (
        .rd        (rd),
        .br_target (br_target),
        .src       (src),
        .pc_next   (pc_next)
    );

    assign pc_sel = src;

    exc_save_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_save (
        .clk      (clk),
        .rst      (rst),
        .fault    (rd.fault),
        .pc_in    (ex_pc),
        .cause_in (exc_cause),
        .pc_q     (saved_pc),
        .cause_q  (saved_cause)
    );

    AST_FAULT_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (exc_req && stage_valid[EX_IDX]) |-> (flush[EX_IDX:0] == '1)); // R2
    AST_OLDER_RETIRE: assert property (@(posedge clk) disable iff (rst)
        flush[NSTAGE-1:EX_IDX+1] == '0); // R3
    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (exc_req && stage_valid[EX_IDX]) |-> (pc_sel == 2'd2 && pc_next == TRAP_PC)); // R4
    AST_EMPTY_EX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !stage_valid[EX_IDX] && !br_taken) |-> (flush == '0 && pc_sel == 2'd0)); // R7
    AST_BRANCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (br_taken && !(exc_req && stage_valid[EX_IDX])) |-> (pc_next == br_target && pc_sel == 2'd1)); // R8
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (rst)
        (br_taken && exc_req && stage_valid[EX_IDX]) |-> (pc_next == TRAP_PC)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !br_taken) |-> (flush == '0 && pc_sel == 2'd0 && pc_next == '0)); // R10
endmodule

// File: tb/test_exc_flush_ctrl.sv
module test_exc_flush_ctrl;
    localparam logic [63:0] TRAP = 64'h0000_0000_1C09_0000;

    typedef struct packed {
        logic [4:0]  vld;
        logic [63:0] pc;
        logic        req;
        logic [3:0]  cause;
        logic        br;
        logic [63:0] tgt;
        logic [4:0]  e_flush;
        logic [1:0]  e_sel;
        logic [63:0] e_next;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'b11111, 64'h40, 1'b0, 4'h0, 1'b0, 64'h0,   5'b00000, 2'd0, 64'h0},  // R10 idle
        '{5'b11111, 64'h4C, 1'b1, 4'h2, 1'b0, 64'h0,   5'b00111, 2'd2, TRAP},   // R2 R4 bad opcode
        '{5'b00011, 64'h50, 1'b0, 4'h0, 1'b1, 64'h48,  5'b00001, 2'd1, 64'h48}, // R8 branch
        '{5'b11011, 64'h100,1'b1, 4'h8, 1'b0, 64'h0,   5'b00000, 2'd0, 64'h0},  // R7 empty EX
        '{5'b11111, 64'h200,1'b1, 4'h8, 1'b1, 64'h300, 5'b00111, 2'd2, TRAP},   // R9 both, syscall
        '{5'b11111, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 4'hA, 1'b0, 64'h0, 5'b00111, 2'd2, TRAP}, // R11 arith
        '{5'b11011, 64'h500,1'b1, 4'h2, 1'b1, 64'h60,  5'b00001, 2'd1, 64'h60}, // R7 R8 empty EX + branch
        '{5'b11111, 64'h8,  1'b1, 4'hF, 1'b0, 64'h0,   5'b00111, 2'd2, TRAP}    // R11 code F
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  stage_valid = '0;
    logic [63:0] ex_pc = '0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_cause = '0;
    logic        br_taken = 1'b0;
    logic [63:0] br_target = '0;
    logic [4:0]  flush;
    logic [1:0]  pc_sel;
    logic [63:0] pc_next;
    logic [63:0] saved_pc;
    logic [3:0]  saved_cause;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [63:0] exp_pc = '0;
    logic [3:0]  exp_cause = '0;

    always #4 clk = ~clk;

    exc_flush_ctrl i_exc_flush_ctrl (
        .clk(clk), .rst(rst), .stage_valid(stage_valid), .ex_pc(ex_pc),
        .exc_req(exc_req), .exc_cause(exc_cause), .br_taken(br_taken),
        .br_target(br_target), .flush(flush), .pc_sel(pc_sel), .pc_next(pc_next),
        .saved_pc(saved_pc), .saved_cause(saved_cause)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_saved(string tag);
        chk({tag, " saved_pc"}, saved_pc, exp_pc);
        chk({tag, " saved_cause"}, {60'd0, saved_cause}, {60'd0, exp_cause});
    endtask

    initial begin
        @(posedge clk);
        @(posedge clk);
        #1;
        chk_saved("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            stage_valid = VECS[i].vld;
            ex_pc       = VECS[i].pc;
            exc_req     = VECS[i].req;
            exc_cause   = VECS[i].cause;
            br_taken    = VECS[i].br;
            br_target   = VECS[i].tgt;
            #2;
            chk("R2/R3 flush", {59'd0, flush}, {59'd0, VECS[i].e_flush});
            chk("R4/R8/R9 pc_sel", {62'd0, pc_sel}, {62'd0, VECS[i].e_sel});
            chk("R4/R8/R10 pc_next", pc_next, VECS[i].e_next);
            if (VECS[i].req && VECS[i].vld[2]) begin
                exp_pc    = VECS[i].pc;
                exp_cause = VECS[i].cause;
            end
            @(posedge clk);
            #1;
            chk_saved("R5/R7/R11 table");
        end

        // R6: hold over idle cycles
        @(negedge clk);
        exc_req = 1'b0; br_taken = 1'b0; stage_valid = 5'b11111;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            chk_saved("R6 hold");
        end

        // R3: fault with every stage valid leaves memory and write-back alone
        @(negedge clk);
        exc_req = 1'b1; exc_cause = 4'hA; ex_pc = 64'h77; br_taken = 1'b1;
        #2;
        chk("R3 older stages kept", {62'd0, flush[4:3]}, 64'd0);
        exp_pc = 64'h77; exp_cause = 4'hA;
        @(posedge clk);
        #1;
        chk_saved("R5 capture");

        // R1: reset after the registers hold values
        @(negedge clk);
        exc_req = 1'b0; br_taken = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        exp_pc = '0; exp_cause = '0;
        chk_saved("R1 late reset");
        @(negedge clk);
        rst = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule